// File: doc/BRIEF.md
# PCIe TLP Trace Filter and Entry Formatter

This block sits beside a set of monitored PCIe ports and looks at one transaction-layer packet header at a time. For each header it decides whether to record it. The decision uses the port the header came from, its class (posted, non-posted or completion) and its direction (inbound or outbound). Inbound completions are split into two subtypes, and some direction codes select these subtypes separately. What a direction code means depends on the chosen entry format.

Each accepted header becomes a fixed-length trace entry of four or eight 32-bit words. The entry is sent out one word per cycle on a valid/ready stream, with a flag on the final word. While an entry is being sent, the header input is held off. Every cycle in which a header is offered but refused adds one to a saturating drop counter. A reserved format or direction setting blocks all recording and sets a sticky error flag.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset, `out_valid` = 0, `hdr_ready` = 1, `cfg_err` = 0 and `drop_count` = 0.
- R2: A header whose `hdr_port` index has a 0 in `cfg_port_mask` is never recorded.
- R3: `hdr_class` codes are 0 = posted, 1 = non-posted, 2 = completion and 3 = invalid. A header of class c is recorded only if `cfg_class[c]` is 1 and c is not 3. Bits 7:3 of `cfg_class` have no effect.
- R4: With `cfg_fmt` = 0 (4-word entries), `hdr_outbound` = 1 marks outbound traffic, and a completion with `hdr_cpl_b` = 0 counts as subtype A. The `cfg_dir` codes keep the following headers:
  - 0: all inbound headers.
  - 1: all outbound headers.
  - 2: all outbound headers, plus inbound headers that are not subtype-A completions.
  - 3: all outbound headers, plus inbound subtype-A completions.
- R5: With `cfg_fmt` = 1 (8-word entries), the `cfg_dir` codes keep the following headers:
  - 1: outbound headers only.
  - 2: inbound headers that are not subtype-A completions.
  - 3: inbound subtype-A completions only.
- R6: A 4-word entry has this layout:
  - Word 0 is {`timestamp`[19:0], `hdr_outbound`, `hdr_cpl_b`, `hdr_class`[1:0], port index zero-extended to 8 bits}. The 8-bit port field occupies bits 7:0.
  - Words 1 to 3 are header words 1 to 3 (`hdr_dw`[1] to `hdr_dw`[3]).
- R7: An 8-word entry has this layout:
  - Words 0 to 3 are header words 0 to 3.
  - Word 4 is `timestamp`.
  - Word 5 is `hdr_prefix` when `hdr_prefix_valid` = 1, and 0 otherwise.
  - Words 6 and 7 are 0.
- R8: The setting is reserved when any of these holds: `cfg_fmt` > 1, `cfg_dir` > 3, or `cfg_fmt` = 1 with `cfg_dir` = 0. While the setting is reserved, no header is recorded. `cfg_err` goes to 1 one cycle after any cycle with a reserved setting, and stays at 1 until reset.
- R9: The first word of an entry is valid in the cycle after its header is accepted. Words advance only on cycles with `out_valid` and `out_ready` both 1, and `out_data` is held while the output is stalled. `out_last` is 1 exactly on the final word, and `out_valid` falls after the final word is taken.
- R10: `hdr_ready` is 0 from the cycle after a recorded header is accepted until the cycle after its final word is taken. Each clock cycle in which `hdr_valid` = 1 and `hdr_ready` = 0 increments `drop_count`, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_mask | input | NUM_PORTS | Per-port enable mask |
| cfg_class | input | 8 | Class selection bits |
| cfg_fmt | input | 4 | Entry format code |
| cfg_dir | input | 4 | Direction selection code |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_dw | input | 4x32 | Header words 0 to 3 |
| hdr_outbound | input | 1 | 1 = outbound, 0 = inbound |
| hdr_class | input | 2 | Packet class code |
| hdr_cpl_b | input | 1 | Completion subtype B flag |
| hdr_port | input | PORT_W | Source port index |
| hdr_prefix_valid | input | 1 | Prefix word present |
| hdr_prefix | input | 32 | Prefix word |
| timestamp | input | 32 | Free-running time value |
| out_valid | output | 1 | Trace word valid |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | 32 | Trace word |
| out_last | output | 1 | Final word of an entry |
| cfg_err | output | 1 | Sticky reserved-setting flag |
| drop_count | output | CNT_W | Saturating count of refused header cycles |

## Verification
A recorded header's first entry word is due one cycle after the edge that accepts it. Each further word is due one cycle after the previous word is taken. The bench drives inputs on falling edges and samples on the next falling edge after each counted edge. For rejected headers, the bench checks that `out_valid` stays low for three cycles. `drop_count` and `cfg_err` each change one cycle after the cycle that causes them. The bench therefore predicts their values at each falling edge from the number of refused or reserved cycles that came before.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

  localparam int DW_W         = 32;
  localparam int HDR_WORDS    = 4;
  localparam int ENTRY_WORDS  = 2 * HDR_WORDS;

  typedef logic [DW_W-1:0] dword_t;

  typedef enum logic [1:0] {
    CLS_POSTED  = 2'd0,
    CLS_NONPOST = 2'd1,
    CLS_CPL     = 2'd2,
    CLS_INVALID = 2'd3
  } tlp_class_e;

  typedef struct packed {
    logic       outbound;
    logic       cpl_b;
    tlp_class_e cls;
    logic [7:0] port;
  } pkt_tag_t;

  localparam int TAG_W   = $bits(pkt_tag_t);
  localparam int TS_KEEP = DW_W - TAG_W;

  localparam logic [3:0] FMT_SHORT = 4'd0;
  localparam logic [3:0] FMT_LONG  = 4'd1;

  function automatic logic setting_ok(input logic [3:0] fmt, input logic [3:0] dir);
    logic ok;
    ok = 1'b0;
    if (fmt == FMT_SHORT) ok = (dir <= 4'd3);
    else if (fmt == FMT_LONG) ok = (dir >= 4'd1) && (dir <= 4'd3);
    return ok;
  endfunction

endpackage

// File: rtl/tlp_filter_decide.sv
module tlp_filter_decide
  import tlp_trace_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] cfg_port_mask_i,
  input  logic [7:0]           cfg_class_i,
  input  logic [3:0]           cfg_fmt_i,
  input  logic [3:0]           cfg_dir_i,
  input  logic                 pkt_outbound_i,
  input  tlp_class_e           pkt_class_i,
  input  logic                 pkt_cpl_b_i,
  input  logic [PORT_W-1:0]    pkt_port_i,
  output logic                 keep_o,
  output logic                 setting_ok_o
);

  logic port_hit;
  logic class_hit;
  logic dir_hit;
  logic cpl_a;
  logic inb_not_a;
  logic unused_cls_bits;

  assign unused_cls_bits = ^cfg_class_i[7:3];

  always_comb begin
    port_hit = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (pkt_port_i == PORT_W'(p)) port_hit = cfg_port_mask_i[p];
    end
  end

  always_comb begin
    unique case (pkt_class_i)
      CLS_POSTED:  class_hit = cfg_class_i[0];
      CLS_NONPOST: class_hit = cfg_class_i[1];
      CLS_CPL:     class_hit = cfg_class_i[2];
      default:     class_hit = 1'b0;
    endcase
  end

  assign cpl_a     = (pkt_class_i == CLS_CPL) && !pkt_cpl_b_i;
  assign inb_not_a = !pkt_outbound_i && !cpl_a;

  always_comb begin
    dir_hit = 1'b0;
    if (cfg_fmt_i == FMT_SHORT) begin
      case (cfg_dir_i)
        4'd0:    dir_hit = !pkt_outbound_i;
        4'd1:    dir_hit = pkt_outbound_i;
        4'd2:    dir_hit = pkt_outbound_i || inb_not_a;
        4'd3:    dir_hit = pkt_outbound_i || (!pkt_outbound_i && cpl_a);
        default: dir_hit = 1'b0;
      endcase
    end else begin
      case (cfg_dir_i)
        4'd1:    dir_hit = pkt_outbound_i;
        4'd2:    dir_hit = inb_not_a;
        4'd3:    dir_hit = !pkt_outbound_i && cpl_a;
        default: dir_hit = 1'b0;
      endcase
    end
  end

  assign setting_ok_o = setting_ok(cfg_fmt_i, cfg_dir_i);
  assign keep_o       = setting_ok_o && port_hit && class_hit && dir_hit;

  always_comb begin
    assert_keep_needs_class_R3: assert (!keep_o || (pkt_class_i != CLS_INVALID));
  end

endmodule

// File: rtl/tlp_entry_build.sv
module tlp_entry_build
  import tlp_trace_pkg::*;
(
  input  logic                            long_fmt_i,
  input  dword_t [HDR_WORDS-1:0]          hdr_i,
  input  pkt_tag_t                        tag_i,
  input  dword_t                          ts_i,
  input  logic                            pfx_valid_i,
  input  dword_t                          pfx_i,
  output dword_t [ENTRY_WORDS-1:0]        entry_o
);

  dword_t head_short;

  assign head_short = {ts_i[TS_KEEP-1:0], tag_i};

  for (genvar w = 0; w < ENTRY_WORDS; w++) begin : g_word
    if (w == 0) begin : g_head
      assign entry_o[w] = long_fmt_i ? hdr_i[0] : head_short;
    end else if (w < HDR_WORDS) begin : g_hdr
      assign entry_o[w] = hdr_i[w];
    end else if (w == HDR_WORDS) begin : g_ts
      assign entry_o[w] = long_fmt_i ? ts_i : '0;
    end else if (w == HDR_WORDS + 1) begin : g_pfx
      assign entry_o[w] = (long_fmt_i && pfx_valid_i) ? pfx_i : '0;
    end else begin : g_zero
      assign entry_o[w] = '0;
    end
  end

endmodule

// File: rtl/tlp_entry_serializer.sv
module tlp_entry_serializer
  import tlp_trace_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  dword_t [ENTRY_WORDS-1:0]  load_entry_i,
  input  logic                      load_long_i,
  input  logic                      out_ready_i,
  output logic                      busy_o,
  output logic                      out_valid_o,
  output dword_t                    out_data_o,
  output logic                      out_last_o
);

  localparam int IDX_W = $clog2(ENTRY_WORDS);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(ENTRY_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(HDR_WORDS - 1);

  dword_t [ENTRY_WORDS-1:0] entry_q;
  logic                     long_q;
  logic                     busy_q,  busy_d;
  logic [IDX_W-1:0]         idx_q,   idx_d;
  logic                     at_last;
  logic                     entry_en;

  assign at_last  = (idx_q == (long_q ? LAST_LONG : LAST_SHORT));
  assign entry_en = load_i;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && out_ready_i) begin
      if (at_last) busy_d = 1'b0;
      else         idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (entry_en) begin
      entry_q <= load_entry_i;
      long_q  <= load_long_i;
    end
  end

  assign busy_o      = busy_q;
  assign out_valid_o = busy_q;
  assign out_data_o  = entry_q[idx_q];
  assign out_last_o  = busy_q && at_last;

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  assert_end_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);

endmodule

// File: rtl/tlp_drop_counter.sv
module tlp_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc_i && (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_drop_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  assert_drop_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
  import tlp_trace_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        cfg_port_mask,
  input  logic [7:0]                  cfg_class,
  input  logic [3:0]                  cfg_fmt,
  input  logic [3:0]                  cfg_dir,
  input  logic                        hdr_valid,
  output logic                        hdr_ready,
  input  logic [HDR_WORDS-1:0][31:0]  hdr_dw,
  input  logic                        hdr_outbound,
  input  logic [1:0]                  hdr_class,
  input  logic                        hdr_cpl_b,
  input  logic [PORT_W-1:0]           hdr_port,
  input  logic                        hdr_prefix_valid,
  input  logic [31:0]                 hdr_prefix,
  input  logic [31:0]                 timestamp,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [31:0]                 out_data,
  output logic                        out_last,
  output logic                        cfg_err,
  output logic [CNT_W-1:0]            drop_count
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tlp_class_e               cls;
  logic                     keep;
  logic                     set_ok;
  logic                     busy;
  logic                     accept;
  logic                     load;
  logic                     drop_inc;
  pkt_tag_t                 tag;
  dword_t [ENTRY_WORDS-1:0] entry;
  logic                     err_q, err_d;

  assign cls = tlp_class_e'(hdr_class);

  tlp_filter_decide #(.NUM_PORTS(NUM_PORTS)) u_decide (
    .cfg_port_mask_i (cfg_port_mask),
    .cfg_class_i     (cfg_class),
    .cfg_fmt_i       (cfg_fmt),
    .cfg_dir_i       (cfg_dir),
    .pkt_outbound_i  (hdr_outbound),
    .pkt_class_i     (cls),
    .pkt_cpl_b_i     (hdr_cpl_b),
    .pkt_port_i      (hdr_port),
    .keep_o          (keep),
    .setting_ok_o    (set_ok)
  );

  assign tag.outbound = hdr_outbound;
  assign tag.cpl_b    = hdr_cpl_b;
  assign tag.cls      = cls;
  assign tag.port     = 8'(hdr_port);

  tlp_entry_build u_build (
    .long_fmt_i  (cfg_fmt == FMT_LONG),
    .hdr_i       (hdr_dw),
    .tag_i       (tag),
    .ts_i        (timestamp),
    .pfx_valid_i (hdr_prefix_valid),
    .pfx_i       (hdr_prefix),
    .entry_o     (entry)
  );

  assign hdr_ready = !busy;
  assign accept    = hdr_valid && hdr_ready;
  assign load      = accept && keep;
  assign drop_inc  = hdr_valid && !hdr_ready;

  tlp_entry_serializer u_ser (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_i       (load),
    .load_entry_i (entry),
    .load_long_i  (cfg_fmt == FMT_LONG),
    .out_ready_i  (out_ready),
    .busy_o       (busy),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data),
    .out_last_o   (out_last)
  );

  tlp_drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc_i   (drop_inc),
    .count_o (drop_count)
  );

  always_comb begin
    err_d = err_q;
    if (!set_ok) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign cfg_err = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_err |=> cfg_err);

  assert_reserved_blocks_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !set_ok) |=> !out_valid);

  assert_first_word_next_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |=> (out_valid && !hdr_ready));

  assert_masked_port_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !cfg_port_mask[hdr_port]) |=> !out_valid);

endmodule

// File: tb/tlp_trace_filter_tb_top.sv
`timescale 1ns/1ps
module tlp_trace_filter_tb_top;

  localparam int NP = 4;
  localparam int CW = 8;

  logic              clk;
  logic              rst_n;
  logic [NP-1:0]     cfg_port_mask;
  logic [7:0]        cfg_class;
  logic [3:0]        cfg_fmt;
  logic [3:0]        cfg_dir;
  logic              hdr_valid;
  logic              hdr_ready;
  logic [3:0][31:0]  hdr_dw;
  logic              hdr_outbound;
  logic [1:0]        hdr_class;
  logic              hdr_cpl_b;
  logic [1:0]        hdr_port;
  logic              hdr_prefix_valid;
  logic [31:0]       hdr_prefix;
  logic [31:0]       timestamp;
  logic              out_valid;
  logic              out_ready;
  logic [31:0]       out_data;
  logic              out_last;
  logic              cfg_err;
  logic [CW-1:0]     drop_count;

  int n_cmp;
  int n_bad;
  bit done;
  int seq;

  tlp_trace_filter #(.NUM_PORTS(NP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_port_mask(cfg_port_mask), .cfg_class(cfg_class),
    .cfg_fmt(cfg_fmt), .cfg_dir(cfg_dir), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dw(hdr_dw), .hdr_outbound(hdr_outbound), .hdr_class(hdr_class),
    .hdr_cpl_b(hdr_cpl_b), .hdr_port(hdr_port), .hdr_prefix_valid(hdr_prefix_valid),
    .hdr_prefix(hdr_prefix), .timestamp(timestamp), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .cfg_err(cfg_err), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic model_keep();
    logic ok, ch, dh, cpl_a, inb_b;
    ok = (cfg_fmt == 4'd0 && cfg_dir <= 4'd3) ||
         (cfg_fmt == 4'd1 && cfg_dir >= 4'd1 && cfg_dir <= 4'd3);
    ch = (hdr_class != 2'd3) && cfg_class[hdr_class];
    cpl_a = (hdr_class == 2'd2) && !hdr_cpl_b;
    inb_b = !hdr_outbound && !cpl_a;
    dh = 1'b0;
    if (cfg_fmt == 4'd0) begin
      case (cfg_dir)
        4'd0: dh = !hdr_outbound;
        4'd1: dh = hdr_outbound;
        4'd2: dh = hdr_outbound || inb_b;
        4'd3: dh = hdr_outbound || (!hdr_outbound && cpl_a);
        default: dh = 1'b0;
      endcase
    end else begin
      case (cfg_dir)
        4'd1: dh = hdr_outbound;
        4'd2: dh = inb_b;
        4'd3: dh = !hdr_outbound && cpl_a;
        default: dh = 1'b0;
      endcase
    end
    return ok && ch && dh && cfg_port_mask[hdr_port];
  endfunction

  function automatic logic [31:0] model_word(input int i);
    logic [31:0] w;
    w = 32'h0;
    if (cfg_fmt == 4'd0) begin
      if (i == 0) w = {timestamp[19:0], hdr_outbound, hdr_cpl_b, hdr_class, 6'b0, hdr_port};
      else        w = hdr_dw[i];
    end else begin
      if (i < 4)       w = hdr_dw[i];
      else if (i == 4) w = timestamp;
      else if (i == 5) w = hdr_prefix_valid ? hdr_prefix : 32'h0;
    end
    return w;
  endfunction

  task automatic set_pkt(input logic ob, input logic [1:0] cls, input logic cb, input logic [1:0] port);
    seq++;
    hdr_outbound = ob;
    hdr_class    = cls;
    hdr_cpl_b    = cb;
    hdr_port     = port;
    for (int i = 0; i < 4; i++) hdr_dw[i] = 32'h1000_0000 * (i + 1) + seq * 32'h111;
    timestamp        = 32'hA5C3_0000 + seq * 32'h1357;
    hdr_prefix_valid = seq[0];
    hdr_prefix       = 32'hBEEF_0000 + seq;
  endtask

  // Drives the header for one cycle, then checks the entry or its absence.
  task automatic send_pkt(input string req);
    logic k;
    logic [31:0] e [8];
    int n;
    @(negedge clk);
    k = model_keep();
    n = (cfg_fmt == 4'd1) ? 8 : 4;
    for (int i = 0; i < 8; i++) e[i] = model_word(i);
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    if (k) begin
      for (int i = 0; i < n; i++) begin
        chk(req, $sformatf("seq %0d word %0d valid", seq, i), {31'b0, out_valid}, 32'd1);
        chk(req, $sformatf("seq %0d word %0d data", seq, i), out_data, e[i]);
        chk(req, $sformatf("seq %0d word %0d last", seq, i), {31'b0, out_last}, {31'b0, i == n - 1});
        chk("R10", $sformatf("seq %0d ready low", seq), {31'b0, hdr_ready}, 32'd0);
        @(negedge clk);
      end
      chk("R9", $sformatf("seq %0d valid falls", seq), {31'b0, out_valid}, 32'd0);
      chk("R10", $sformatf("seq %0d ready back", seq), {31'b0, hdr_ready}, 32'd1);
    end else begin
      for (int c = 0; c < 3; c++) begin
        chk(req, $sformatf("seq %0d no entry", seq), {31'b0, out_valid}, 32'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1", "hdr_ready", {31'b0, hdr_ready}, 32'd1);
    chk("R1", "cfg_err", {31'b0, cfg_err}, 32'd0);
    chk("R1", "drop_count", 32'(drop_count), 32'd0);
  endtask

  task automatic t_port_mask();
    cfg_fmt = 4'd0; cfg_dir = 4'd1; cfg_class = 8'h07; cfg_port_mask = 4'b0101;
    for (int p = 0; p < 4; p++) begin
      set_pkt(1'b1, 2'd0, 1'b0, 2'(p));
      send_pkt("R2");
    end
    cfg_port_mask = 4'b1010;
    for (int p = 0; p < 4; p++) begin
      set_pkt(1'b1, 2'd1, 1'b0, 2'(p));
      send_pkt("R2");
    end
  endtask

  task automatic t_class();
    logic [7:0] sel [5];
    sel[0] = 8'h01; sel[1] = 8'h02; sel[2] = 8'h04; sel[3] = 8'hF8; sel[4] = 8'hFF;
    cfg_fmt = 4'd0; cfg_dir = 4'd1; cfg_port_mask = 4'hF;
    for (int s = 0; s < 5; s++) begin
      cfg_class = sel[s];
      for (int c = 0; c < 4; c++) begin
        set_pkt(1'b1, 2'(c), 1'b1, 2'd2);
        send_pkt("R3");
      end
    end
  endtask

  task automatic t_dir(input logic [3:0] fmt, input string req);
    cfg_fmt = fmt; cfg_class = 8'h07; cfg_port_mask = 4'hF;
    for (int d = 0; d < 4; d++) begin
      if (!(fmt == 4'd1 && d == 0)) begin
        cfg_dir = 4'(d);
        for (int ob = 0; ob < 2; ob++) begin
          for (int k = 0; k < 4; k++) begin
            set_pkt(ob[0], (k < 2) ? 2'(k) : 2'd2, (k == 3), 2'(k));
            send_pkt(req);
          end
        end
      end
    end
  endtask

  task automatic t_stall_drop();
    logic [31:0] w0;
    logic [31:0] e [8];
    cfg_fmt = 4'd1; cfg_dir = 4'd1; cfg_class = 8'h07; cfg_port_mask = 4'hF;
    @(negedge clk);
    set_pkt(1'b1, 2'd1, 1'b0, 2'd3);
    for (int i = 0; i < 8; i++) e[i] = model_word(i);
    w0 = e[0];
    out_ready = 1'b0;
    hdr_valid = 1'b1;
    @(negedge clk);
    for (int k = 1; k < 300; k++) begin
      if (k == 1 || k == 10 || k == 100) begin
        chk("R9", $sformatf("stall %0d valid", k), {31'b0, out_valid}, 32'd1);
        chk("R9", $sformatf("stall %0d data held", k), out_data, w0);
        chk("R10", $sformatf("drop count at %0d", k), 32'(drop_count), 32'(k - 1));
      end
      @(negedge clk);
    end
    hdr_valid = 1'b0;
    chk("R10", "drop count saturated", 32'(drop_count), 32'd255);
    chk("R9", "data held after long stall", out_data, w0);
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R7", $sformatf("long word %0d", i), out_data, e[i]);
      chk("R9", $sformatf("long last %0d", i), {31'b0, out_last}, {31'b0, i == 7});
      @(negedge clk);
    end
    chk("R9", "valid falls after long entry", {31'b0, out_valid}, 32'd0);
    chk("R10", "drop count stays saturated", 32'(drop_count), 32'd255);
  endtask

  task automatic t_reserved();
    cfg_fmt = 4'd0; cfg_dir = 4'd1; cfg_class = 8'h07; cfg_port_mask = 4'hF;
    @(negedge clk);
    chk("R8", "err clear on valid setting", {31'b0, cfg_err}, 32'd0);
    cfg_fmt = 4'd1; cfg_dir = 4'd0;
    @(negedge clk);
    chk("R8", "err set one cycle later", {31'b0, cfg_err}, 32'd1);
    set_pkt(1'b1, 2'd0, 1'b0, 2'd0);
    send_pkt("R8");
    cfg_fmt = 4'd0; cfg_dir = 4'd7;
    set_pkt(1'b1, 2'd0, 1'b0, 2'd1);
    send_pkt("R8");
    cfg_fmt = 4'd1; cfg_dir = 4'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R8", "err sticky", {31'b0, cfg_err}, 32'd1);
    set_pkt(1'b1, 2'd0, 1'b0, 2'd2);
    send_pkt("R7");
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0; seq = 0;
    rst_n = 1'b0; hdr_valid = 1'b0; out_ready = 1'b1;
    cfg_port_mask = 4'hF; cfg_class = 8'h07; cfg_fmt = 4'd0; cfg_dir = 4'd1;
    set_pkt(1'b0, 2'd0, 1'b0, 2'd0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_port_mask();
    t_class();
    t_dir(4'd0, "R4");
    t_dir(4'd0, "R6");
    t_dir(4'd1, "R5");
    t_stall_drop();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule